// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block produces three independent square-wave outputs for neighbouring chips or for the rest of the die. Each output takes one of two source rates and divides it down. The low-rate source nominally runs at 32768 Hz and the high-rate source at 4 MHz. Both sources arrive as one-cycle tick enables inside a single fast system clock domain. Each output is a registered signal that toggles after a programmed number of source ticks.

Every output has an 8-bit control byte, and the three bytes sit at consecutive addresses starting at a base address. A plain address/data/write-strobe port sets each byte, and the same port reads it back. The high-rate path has a prescaler ahead of the power-of-two post-divider, and it has one irregular code. A new setting is adopted only at the moment an output is about to rise, so no pulse is ever cut short.

Top module: `clkout_gen`

## Requirements
- R1: After a synchronous reset, all three control bytes read 0 and all outputs are low.
- R2: A write to address BASE+i (i = 0, 1, 2) stores wdata as control byte i, and reading that address returns the stored byte. Any other address reads 0, and writes to it change no byte and no output.
- R3: Bit 0 of a control byte enables its output. While the output is disabled, it is held low and never toggles.
- R4: Bits [3:1] hold a post-divide code n. The selected (and possibly prescaled) source is divided by 2^n, so n = 0..7 gives ratios 1..128.
- R5: Bit 4 selects the source. 0 selects the low-rate tick, and 1 selects the high-rate tick. Output edges occur only on ticks of the selected source.
- R6: Bits [7:5] hold a prescale code p, which applies only on the high-rate source. Codes 0..6 divide by 2^p, and code 7 divides by 122.
- R7: When the low-rate source is selected, the prescale field has no effect.
- R8: With total ratio D (prescale times post-divide), each high phase and each low phase lasts exactly D ticks of the selected source. This gives 50% duty for every ratio, and D = 1 toggles on every tick.
- R9: A changed control byte takes effect only at the end of a low phase. A high phase that is in progress always completes with the ratio it started with.
- R10: The three outputs run independently. Programming one output leaves the others' timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow | input | 1 | One-cycle enable at the low source rate |
| tick_fast | input | 1 | One-cycle enable at the high source rate |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| clk_out | output | 3 | Divided clock outputs |

## Verification
The assertions take for granted that both tick inputs are synchronous to clk and are sampled once per cycle as plain enables. They also assume that reset is held for at least one edge before any check applies. The stimulus drives the ticks and all bus signals only on falling edges. Tick patterns come from a seeded random draw, and their density is kept low enough that every divide ratio completes within the run. The bench counts the selected source's ticks itself to time each phase, so its expected durations depend only on the control byte.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    localparam int CNT_W   = 14;   // holds 122 << 7
    localparam int PRE_ODD = 122;  // ratio used by prescale code 7

    typedef struct packed {
        logic [2:0] pre;       // [7:5] prescale code, high-rate path only
        logic       src_fast;  // [4]   source select
        logic [2:0] post;      // [3:1] power-of-two post-divide
        logic       en;        // [0]   output enable
    } ctl_t;

    function automatic logic [CNT_W-1:0] span(ctl_t c);
        logic [CNT_W-1:0] base;
        if (!c.src_fast)
            base = CNT_W'(1);
        else if (c.pre == 3'd7)
            base = CNT_W'(PRE_ODD);
        else
            base = CNT_W'(1) << c.pre;
        return base << c.post;
    endfunction

endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
    import clkout_pkg::*;
#(
    parameter int N    = 3,
    parameter int AW   = 8,
    parameter int BASE = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output ctl_t [N-1:0]        ctl_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    ctl_t [N-1:0]   regs_q;
    logic [AW-1:0]  offs;
    logic [IW-1:0]  idx;
    logic           hit;

    assign offs  = addr - AW'(BASE);
    assign idx   = offs[IW-1:0];
    assign hit   = (addr >= AW'(BASE)) && (offs < AW'(N));
    assign rdata = hit ? regs_q[idx] : 8'h00;
    assign ctl_o = regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en && hit) begin
            regs_q[idx] <= ctl_t'(wdata);
        end
    end

    // R2: a mapped write lands in the addressed byte
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> (regs_q[$past(idx)] == ctl_t'($past(wdata))));

    // R2: an unmapped write disturbs nothing
    p_stray_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit) |=> $stable(regs_q));

endmodule

// File: rtl/clkout_chan.sv
module clkout_chan
    import clkout_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_slow,
    input  logic tick_fast,
    input  ctl_t ctl,
    output logic out
);
    ctl_t              act_q;    // setting in force
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lim;
    logic              out_q;
    logic              tick;

    assign tick = act_q.src_fast ? tick_fast : tick_slow;
    assign lim  = span(act_q);
    assign out  = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (!act_q.en) begin
            act_q <= ctl;          // idle: track the register freely
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (tick) begin
            if (cnt_q == lim - CNT_W'(1)) begin
                cnt_q <= '0;
                if (out_q) begin
                    out_q <= 1'b0;
                end else begin
                    act_q <= ctl;  // end of low phase: adopt new setting
                    out_q <= ctl.en;
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    p_off_low_r3: assert property (@(posedge clk) disable iff (rst)
        !act_q.en |-> !out_q);

    p_hold_in_high_r9: assert property (@(posedge clk) disable iff (rst)
        out_q |=> $stable(act_q));

    p_cnt_range_r8: assert property (@(posedge clk) disable iff (rst)
        act_q.en |-> (cnt_q < lim));

    p_edge_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (out_q != $past(out_q)) |-> $past(tick));

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
    import clkout_pkg::*;
#(
    parameter int N    = 3,
    parameter int AW   = 8,
    parameter int BASE = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_slow,
    input  logic          tick_fast,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic [N-1:0]  clk_out
);
    ctl_t [N-1:0] ctl;

    clkout_regs #(.N(N), .AW(AW), .BASE(BASE)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .ctl_o (ctl)
    );

    for (genvar g = 0; g < N; g++) begin : g_chan
        clkout_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .tick_slow (tick_slow),
            .tick_fast (tick_fast),
            .ctl       (ctl[g]),
            .out       (clk_out[g])
        );
    end

    // R1: outputs are low in the cycle after reset
    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> (clk_out == '0));

endmodule

// File: tb/clkout_gen_test.sv
module clkout_gen_test;
    localparam int BASE = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_slow = 1'b0;
    logic       tick_fast = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] clk_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    int  cnt_m [3];
    int  hi_len [3];
    int  lo_len [3];
    int  rises [3];
    int  falls [3];
    logic prev [3];
    logic sel_m [3];

    clkout_gen uut (
        .clk(clk), .rst(rst), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .clk_out(clk_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // monitor: tick counts per phase, then new tick values
    always @(negedge clk) begin
        for (int c = 0; c < 3; c++) begin
            if (rst) begin
                cnt_m[c] = 0; prev[c] = 1'b0;
            end else begin
                if (sel_m[c] ? tick_fast : tick_slow) cnt_m[c] = cnt_m[c] + 1;
                if (clk_out[c] != prev[c]) begin
                    if (clk_out[c]) begin lo_len[c] = cnt_m[c]; rises[c] = rises[c] + 1; end
                    else begin hi_len[c] = cnt_m[c]; falls[c] = falls[c] + 1; end
                    cnt_m[c] = 0;
                end
                prev[c] = clk_out[c];
            end
        end
        tick_fast = ($urandom % 3) == 0;
        tick_slow = ($urandom % 4) == 0;
    end

    function automatic int exp_span(logic [7:0] code);
        int b;
        if (!code[4]) b = 1;
        else if (code[7:5] == 3'd7) b = 122;
        else b = 1 << code[7:5];
        return b << code[3:1];
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr(int ch_addr, logic [7:0] d);
        @(negedge clk);
        addr = 8'(ch_addr); wdata = d; wr_en = 1'b1;
        if (ch_addr >= BASE && ch_addr < BASE + 3) sel_m[ch_addr - BASE] = d[4];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(int a, logic [7:0] expv, string tag);
        @(negedge clk);
        addr = 8'(a);
        #1;
        chk(rdata == expv, tag, rdata, expv);
    endtask

    task automatic measure(int ch, logic [7:0] code, string tag);
        int base;
        @(negedge clk);
        base = rises[ch];
        while (rises[ch] < base + 2) @(negedge clk);
        chk(hi_len[ch] == exp_span(code), {tag, " high"}, hi_len[ch], exp_span(code));
        chk(lo_len[ch] == exp_span(code), {tag, " low"}, lo_len[ch], exp_span(code));
    endtask

    initial begin
        logic [7:0] code;
        int r, f, ch;
        void'($urandom(32'd1234));
        for (int c = 0; c < 3; c++) begin
            sel_m[c] = 1'b0; rises[c] = 0; falls[c] = 0; hi_len[c] = 0; lo_len[c] = 0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int c = 0; c < 3; c++) rd_chk(BASE + c, 8'h00, "R1 reg");
        chk(clk_out == 3'b000, "R1 out", clk_out, 0);

        // R2 unmapped address
        wr(BASE + 3, 8'hFF);
        wr(BASE - 1, 8'hFF);
        rd_chk(BASE + 3, 8'h00, "R2 unmapped read");
        rd_chk(BASE, 8'h00, "R2 neighbour untouched");
        repeat (200) @(negedge clk);
        chk(clk_out == 3'b000, "R2 R3 no output after stray write", clk_out, 0);

        // R4 R7: low-rate source, prescale field set but ignored
        code = {3'd6, 1'b0, 3'd3, 1'b1};
        wr(BASE, code);
        rd_chk(BASE, code, "R2 readback");
        measure(0, code, "R4 R7 slow /8");

        // R6 prescale code 7 on ch1; R5 R8 ratio 1 on ch2
        wr(BASE + 1, {3'd7, 1'b1, 3'd0, 1'b1});
        wr(BASE + 2, {3'd0, 1'b1, 3'd0, 1'b1});
        measure(1, {3'd7, 1'b1, 3'd0, 1'b1}, "R6 prescale 122");
        measure(2, {3'd0, 1'b1, 3'd0, 1'b1}, "R5 R8 ratio 1");
        measure(0, code, "R10 ch0 unchanged");

        // R9: change mid high phase, high phase must finish at 122
        r = rises[1];
        while (rises[1] == r) @(negedge clk);
        repeat (40) @(negedge clk);
        f = falls[1];
        wr(BASE + 1, {3'd0, 1'b1, 3'd1, 1'b1});
        while (falls[1] == f) @(negedge clk);
        chk(hi_len[1] == 122, "R9 high phase kept", hi_len[1], 122);
        measure(1, {3'd0, 1'b1, 3'd1, 1'b1}, "R9 new ratio");

        // R3 disable: output settles low and stays there
        wr(BASE + 2, 8'h00);
        repeat (2000) @(negedge clk);
        r = rises[2];
        repeat (1000) @(negedge clk);
        chk(rises[2] == r, "R3 no rise while off", rises[2] - r, 0);
        chk(clk_out[2] == 1'b0, "R3 held low", clk_out[2], 0);
        rd_chk(BASE + 2, 8'h00, "R2 readback zero");

        // random settings, ratio kept at or below 256
        for (int i = 0; i < 10; i++) begin
            ch = $urandom % 3;
            do begin
                code = 8'($urandom);
                code[0] = 1'b1;
            end while (exp_span(code) > 256);
            wr(BASE + ch, code);
            rd_chk(BASE + ch, code, "R2 random readback");
            measure(ch, code, code[4] ? "R8 R6 random fast" : "R8 R4 random slow");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule